// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose Parallel Port

This block is a 16-pin general-purpose parallel port. Software controls it through four 16-bit registers on a simple synchronous register bus. The bus has a byte address, a write strobe, write data and combinational read data.

For each pin, the block produces an output value and an output enable for the pad cell. It also takes back the level seen on the pad. Software chooses, pin by pin:
- whether the pin is an input or an output;
- whether it is driven by the general-purpose data latch or by a dedicated peripheral;
- whether the driver is push-pull or open-drain.

Open-drain operation exists only on a fixed set of pins given by a parameter mask (default 0x00FA).

Reading the data register returns the synchronised pad levels, not the latch contents. Software can therefore compare what it wrote with what the pins actually carry and detect a wired conflict.

Top module: `gpio_port16`

## Requirements
- R1: Registers sit at byte offsets 0x0 (open-drain select), 0x2 (direction), 0x4 (pin assignment) and 0x6 (data). A write takes effect at the rising clock edge on which `bus_we` is high. Any other offset reads as zero and a write to it changes no register.
- R2: Only the open-drain bits in `OD_MASK` are implemented (default bits 7, 6, 5, 4, 3 and 1, i.e. 0x00FA). All other open-drain bits read zero whatever was written, and have no effect on any pin.
- R3: For a pin whose open-drain bit is 1, the driven value `pin_out` is always 0. The enable `pin_oe` is 1 only when the pin would otherwise drive a 0, so a 1 leaves the pin at high impedance.
- R4: After reset, the open-drain, direction and pin-assignment registers read zero and every `pin_oe` bit is 0.
- R5: For a general-purpose pin (assignment bit 0) without open-drain, direction bit 1 drives `pin_out` from the data latch with `pin_oe` = 1. Direction bit 0 gives `pin_oe` = 0.
- R6: A data-register write is latched for all 16 bits regardless of direction. A latched value appears on the pin only once its direction bit is set.
- R7: The data-register read returns `pin_in` through a two-flop synchroniser. A level applied before rising edge k is read after edge k+1, and not after edge k.
- R8: The data-register read reflects the pin level, not the latch. An output pin whose pad is held opposite to the latched value reads the pad value.
- R9: With assignment bit 1, `alt_out` and `alt_oe` of that pin replace the data latch and direction bit. Changes to the data and direction registers then have no effect on that pin.
- R10: Open-drain conversion also applies to pins assigned to a peripheral, on the capable positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_in | input | 16 | Levels sampled from the pads |
| pin_out | output | 16 | Value driven to the pads |
| pin_oe | output | 16 | Pad output enables |
| alt_out | input | 16 | Peripheral output values |
| alt_oe | input | 16 | Peripheral output enables |

## Verification
Several properties are checked on every cycle by assertions:
- an open-drain pin never drives a 1;
- an input-configured general-purpose pin never enables its driver;
- assigned pins without open-drain follow the peripheral exactly;
- the unimplemented open-drain bits read zero;
- a data read equals the pin level from two edges earlier.

Other behaviour can only be shown by the bench's scenarios:
- a latched value appearing later, once the direction changes;
- writes to unmapped offsets leaving all state untouched;
- the reset values;
- conflict detection between latch and pad.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PIN_W  = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_OD  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_DIR = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_PAR = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_DAT = 3'd6;

    typedef struct packed {
        logic [PIN_W-1:0] od;
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] par;
        logic [PIN_W-1:0] dat;
    } ctl_regs_t;

    typedef struct packed {
        logic [PIN_W-1:0] s1;
        logic [PIN_W-1:0] s2;
    } sync_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] async_in,
    output logic [PIN_W-1:0] sync_out
);
    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter logic [PIN_W-1:0] OD_MASK = 16'h00FA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [PIN_W-1:0]  wdata,
    input  logic [PIN_W-1:0]  pin_sync,
    output logic [PIN_W-1:0]  rdata,
    output logic [PIN_W-1:0]  od,
    output logic [PIN_W-1:0]  dir,
    output logic [PIN_W-1:0]  par,
    output logic [PIN_W-1:0]  dat
);
    ctl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (addr)
                OFF_OD:  r_d.od  = wdata & OD_MASK;
                OFF_DIR: r_d.dir = wdata;
                OFF_PAR: r_d.par = wdata;
                OFF_DAT: r_d.dat = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (addr)
            OFF_OD:  rdata = r_q.od;
            OFF_DIR: rdata = r_q.dir;
            OFF_PAR: rdata = r_q.par;
            OFF_DAT: rdata = pin_sync;
            default: rdata = '0;
        endcase
    end

    assign od  = r_q.od;
    assign dir = r_q.dir;
    assign par = r_q.par;
    assign dat = r_q.dat;

    assert_od_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFF_OD) |-> ((rdata & ~OD_MASK) == '0));

    assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFF_DIR) |=> (dir == $past(wdata)));

    assert_par_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(we && addr == OFF_PAR)) |=> $stable(par));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pkg::*;
#(
    parameter logic [PIN_W-1:0] OD_MASK = 16'h00FA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] od,
    input  logic [PIN_W-1:0] dir,
    input  logic [PIN_W-1:0] par,
    input  logic [PIN_W-1:0] dat,
    input  logic [PIN_W-1:0] alt_out,
    input  logic [PIN_W-1:0] alt_oe,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe
);
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        logic src_v, src_e, od_on;

        always_comb begin
            src_v = par[i] ? alt_out[i] : dat[i];
            src_e = par[i] ? alt_oe[i]  : dir[i];
            od_on = od[i] & OD_MASK[i];
            if (od_on) begin
                pin_out[i] = 1'b0;
                pin_oe[i]  = src_e & ~src_v;
            end else begin
                pin_out[i] = src_v;
                pin_oe[i]  = src_e;
            end
        end

        assert_od_never_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(od[i] && pin_oe[i] && pin_out[i]));

        assert_input_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!par[i] && !dir[i]) |-> !pin_oe[i]);

        assert_alt_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (par[i] && !od[i]) |-> (pin_out[i] == alt_out[i] && pin_oe[i] == alt_oe[i]));
    end
endmodule

// File: rtl/gpio_port16.sv
module gpio_port16
    import gpio_pkg::*;
#(
    parameter logic [PIN_W-1:0] OD_MASK = 16'h00FA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    input  logic [PIN_W-1:0]  alt_out,
    input  logic [PIN_W-1:0]  alt_oe
);
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] od_w, dir_w, par_w, dat_w;

    gpio_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.OD_MASK(OD_MASK)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata),
        .od       (od_w),
        .dir      (dir_w),
        .par      (par_w),
        .dat      (dat_w)
    );

    gpio_pin_mux #(.OD_MASK(OD_MASK)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .od      (od_w),
        .dir     (dir_w),
        .par     (par_w),
        .dat     (dat_w),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // Edges seen since reset release, saturating; qualifies the latency check.
    logic [1:0] edges_d, edges_q;

    always_comb begin
        edges_d = (edges_q == 2'd2) ? edges_q : edges_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges_q <= '0;
        else        edges_q <= edges_d;
    end

    assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q == 2'd2 && bus_addr == OFF_DAT) |-> (bus_rdata == $past(pin_in, 2)));
endmodule

// File: tb/tb_gpio_port16.sv
module tb_gpio_port16;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in, pin_out, pin_oe, alt_out, alt_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port16 dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clear_all();
        wr(3'd0, 16'h0); wr(3'd2, 16'h0); wr(3'd4, 16'h0); wr(3'd6, 16'h0);
        alt_out = '0; alt_oe = '0; pin_in = '0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); chk("R4", "od after reset", v, 16'h0);
        rd(3'd2, v); chk("R4", "dir after reset", v, 16'h0);
        rd(3'd4, v); chk("R4", "par after reset", v, 16'h0);
        chk("R4", "oe after reset", pin_oe, 16'h0);
    endtask

    task automatic t_map();
        logic [15:0] v;
        wr(3'd2, 16'h1234); rd(3'd2, v); chk("R1", "dir readback", v, 16'h1234);
        wr(3'd4, 16'h0000); rd(3'd4, v); chk("R1", "par readback", v, 16'h0000);
        wr(3'd1, 16'hFFFF); rd(3'd1, v); chk("R1", "odd offset reads zero", v, 16'h0);
        wr(3'd7, 16'hFFFF);
        rd(3'd2, v); chk("R1", "dir untouched by unmapped write", v, 16'h1234);
        rd(3'd4, v); chk("R1", "par untouched by unmapped write", v, 16'h0);
        rd(3'd0, v); chk("R1", "od untouched by unmapped write", v, 16'h0);
        clear_all();
    endtask

    task automatic t_od_mask();
        logic [15:0] v;
        wr(3'd0, 16'hFFFF); rd(3'd0, v); chk("R2", "od readback masked", v, 16'h00FA);
        wr(3'd2, 16'h0101); wr(3'd6, 16'h0101);
        chk("R2", "non-capable pins drive high", pin_out & 16'h0101, 16'h0101);
        chk("R2", "non-capable pins enabled", pin_oe & 16'h0101, 16'h0101);
        clear_all();
    endtask

    task automatic t_pushpull();
        wr(3'd2, 16'hFF00); wr(3'd6, 16'hA5C3);
        chk("R5", "pin_oe follows dir", pin_oe, 16'hFF00);
        chk("R5", "output pins drive latch", pin_out & 16'hFF00, 16'hA500);
        clear_all();
    endtask

    task automatic t_latch_then_dir();
        wr(3'd6, 16'h5A5A);
        chk("R6", "no drive while input", pin_oe, 16'h0);
        wr(3'd2, 16'hFFFF);
        chk("R6", "latched value appears", pin_out, 16'h5A5A);
        chk("R6", "all enabled", pin_oe, 16'hFFFF);
        clear_all();
    endtask

    task automatic t_open_drain();
        wr(3'd0, 16'h0002); wr(3'd2, 16'h0002); wr(3'd6, 16'h0002);
        chk("R3", "od high -> released", pin_oe & 16'h0002, 16'h0);
        chk("R3", "od value low", pin_out & 16'h0002, 16'h0);
        wr(3'd6, 16'h0000);
        chk("R3", "od low -> driven", pin_oe & 16'h0002, 16'h0002);
        chk("R3", "od low value", pin_out & 16'h0002, 16'h0);
        clear_all();
    endtask

    task automatic t_latency();
        logic [15:0] v;
        bus_addr = 3'd6;
        @(negedge clk); pin_in = 16'hBEEF;
        @(posedge clk); #1; rd(3'd6, v);
        chk("R7", "not visible after one edge", v, 16'h0000);
        @(posedge clk); #1; rd(3'd6, v);
        chk("R7", "visible after two edges", v, 16'hBEEF);
        clear_all();
    endtask

    task automatic t_conflict();
        logic [15:0] v;
        wr(3'd2, 16'h00FF); wr(3'd6, 16'h00FF);
        pin_in = 16'h00F0;
        repeat (3) @(posedge clk);
        #1; rd(3'd6, v);
        chk("R8", "read shows pad not latch", v, 16'h00F0);
        clear_all();
    endtask

    task automatic t_alt();
        wr(3'd4, 16'h01F0); wr(3'd2, 16'h0000);
        alt_out = 16'h01A0; alt_oe = 16'h01F0; #1;
        chk("R9", "alt value passed", pin_out & 16'h01F0, 16'h01A0);
        chk("R9", "alt enable passed", pin_oe & 16'h01F0, 16'h01F0);
        wr(3'd6, 16'hFFFF); wr(3'd2, 16'h0000);
        chk("R9", "data/dir ignored on assigned", pin_out & 16'h01F0, 16'h01A0);
        wr(3'd0, 16'h00A0);
        chk("R10", "assigned od pins released", pin_oe & 16'h01F0, 16'h0150);
        chk("R10", "assigned od pins low", pin_out & 16'h00A0, 16'h0);
        clear_all();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        pin_in = '0; alt_out = '0; alt_oe = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        t_reset();
        t_map();
        t_od_mask();
        t_pushpull();
        t_latch_then_dir();
        t_open_drain();
        t_latency();
        t_conflict();
        t_alt();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule